// File: doc/BRIEF.md
# Control Endpoint Descriptor Auto-Responder

This block serves the IN data stage of a control transfer on endpoint 0 without firmware feeding each packet. Firmware places a descriptor in a byte-wide synchronous RAM region. It then programs a 16-bit start address and a 16-bit total byte count, each as a low and a high byte register, and sets the arm bit. Once firmware also drops the endpoint's hold-off bit, every IN token gets one data packet read straight from that RAM. Each packet is as long as the smaller of the bytes left and the configured max packet size.

The read address and the byte count move on only when the host acknowledges a packet. A packet that is not acknowledged is sent again, byte for byte, on the next IN token. When no bytes are left, IN tokens are answered with NAK, and no zero-length packet is ever built. The OUT token of the status stage disarms the block and latches a sticky completion flag. That flag can raise an interrupt.

Top module: `desc_auto_responder`

## Requirements
- R1: After reset, address and count read 0, CTRL reads 0x02 (disarmed, hold-off set, max packet 8), STAT reads 0, and `irq` is low.
- R2: An IN token while the block is armed (CTRL bit 0) and the hold-off bit (CTRL bit 1) is set gets a `nak` pulse and no `pkt_start` or data bytes.
- R3: An IN token while armed, not held off and with bytes left starts a packet. The packet is min(remaining, MPS) bytes long, where CTRL bits 3:2 select an MPS of 8, 16, 32 or 64 (codes 0 to 3). The bytes are read from consecutive RAM addresses starting at the current address, with `tx_last` on the final byte.
- R4: A `host_ack` after a packet adds the packet length to the address (wrapping at 16 bits) and subtracts it from the count. Without an ack, the next IN token resends the same bytes and leaves the address and count unchanged.
- R5: An IN token while armed with a count of 0 gets a `nak` and no packet. This holds after the last full packet of an exact multiple of MPS, and for a transfer armed with a count of 0.
- R6: STAT bit 1 (short-packet enable) and `short_en` are 1 exactly when the block is armed and 0 < remaining < MPS.
- R7: An OUT token while armed clears the arm bit and sets the sticky done bit, STAT bit 0. `irq` equals done AND IRQEN bit 0.
- R8: Writing 1 to STAT bit 0 clears done, and writing 0 leaves it unchanged. If an OUT token sets done in the same cycle, done ends up set.
- R9: While disarmed, IN and OUT tokens produce no `nak`, no packet and no change to done.
- R10: The registers sit at addresses 0 (address low), 1 (address high), 2 (count low), 3 (count high), 4 (CTRL), 5 (STAT) and 6 (IRQEN). Reads return current values, so the address and count read back as they advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| tok_in | input | 1 | IN token for endpoint 0, one-cycle pulse |
| tok_out | input | 1 | OUT token for endpoint 0, one-cycle pulse |
| host_ack | input | 1 | Host ACK of the last data packet, one-cycle pulse |
| ram_rd | output | 1 | Descriptor RAM read enable |
| ram_addr | output | 16 | Descriptor RAM byte address |
| ram_rdata | input | 8 | RAM data, valid one cycle after `ram_rd` |
| pkt_start | output | 1 | Pulse: a data packet begins |
| pkt_len | output | 7 | Length of the packet announced by `pkt_start` |
| tx_valid | output | 1 | Data byte valid toward the packet engine |
| tx_data | output | 8 | Data byte |
| tx_last | output | 1 | Marks the final byte of the packet |
| nak | output | 1 | Pulse: answer this IN token with NAK |
| short_en | output | 1 | Short-packet enable |
| irq | output | 1 | Completion interrupt |

## Verification
Two functions touch the done flag and can meet in one cycle: the status-stage OUT token sets it, and a firmware write-one-to-clear clears it. The bench drives both in the same clock period. It then reads STAT and expects done to stay set, with `irq` still asserted while the interrupt is enabled. A second overlap sets an ack against the hold-off bit. The bench raises hold-off while a packet waits for its ack, then checks that a following IN token is refused with NAK and does not resend the packet.

// File: rtl/dar_pkg.sv
package dar_pkg;

    localparam int REG_AW = 3;
    localparam int LEN_W  = 7;

    typedef enum logic [REG_AW-1:0] {
        RA_ADDR_LO = 3'd0,
        RA_ADDR_HI = 3'd1,
        RA_CNT_LO  = 3'd2,
        RA_CNT_HI  = 3'd3,
        RA_CTRL    = 3'd4,
        RA_STAT    = 3'd5,
        RA_IRQEN   = 3'd6
    } reg_addr_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_SEND = 2'd1,
        SQ_WAIT = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        RSP_NONE = 2'd0,
        RSP_NAK  = 2'd1,
        RSP_DATA = 2'd2
    } rsp_kind_e;

    typedef struct packed {
        logic [1:0] mps_sel;
        logic       hold_off;
        logic       arm;
    } ctrl_t;

    typedef struct packed {
        rsp_kind_e          kind;
        logic [LEN_W-1:0]   len;
    } rsp_t;

    function automatic logic [LEN_W-1:0] mps_bytes(input logic [1:0] sel);
        return LEN_W'(8) << sel;
    endfunction

endpackage

// File: rtl/dar_regs.sv
module dar_regs
    import dar_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [REG_AW-1:0]    addr,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata,
    input  logic                 adv,
    input  logic [LEN_W-1:0]     adv_len,
    input  logic                 out_hit,
    output logic [ADDR_W-1:0]    base,
    output logic [CNT_W-1:0]     remain,
    output ctrl_t                ctrl,
    output logic                 done,
    output logic                 irq_en,
    output logic                 short_en
);

    localparam int AH = ADDR_W - 8;
    localparam int CH = CNT_W - 8;

    logic [LEN_W-1:0] mps;
    assign mps      = mps_bytes(ctrl.mps_sel);
    assign short_en = ctrl.arm && (remain != '0) && (remain < CNT_W'(mps));

    always_ff @(posedge clk) begin
        if (rst) begin
            base   <= '0;
            remain <= '0;
            ctrl   <= '{mps_sel: 2'd0, hold_off: 1'b1, arm: 1'b0};
            done   <= 1'b0;
            irq_en <= 1'b0;
        end else begin
            if (adv) begin
                base   <= base + ADDR_W'(adv_len);
                remain <= remain - CNT_W'(adv_len);
            end
            if (we) begin
                case (reg_addr_e'(addr))
                    RA_ADDR_LO: base[7:0]          <= wdata;
                    RA_ADDR_HI: base[ADDR_W-1:8]   <= wdata[AH-1:0];
                    RA_CNT_LO:  remain[7:0]        <= wdata;
                    RA_CNT_HI:  remain[CNT_W-1:8]  <= wdata[CH-1:0];
                    RA_CTRL:    ctrl               <= ctrl_t'(wdata[3:0]);
                    RA_STAT:    if (wdata[0]) done <= 1'b0;
                    RA_IRQEN:   irq_en             <= wdata[0];
                    default:    ;
                endcase
            end
            if (out_hit) begin
                ctrl.arm <= 1'b0;
                done     <= 1'b1;
            end
        end
    end

    always_comb begin
        rdata = 8'h00;
        case (reg_addr_e'(addr))
            RA_ADDR_LO: rdata = base[7:0];
            RA_ADDR_HI: rdata = 8'(base[ADDR_W-1:8]);
            RA_CNT_LO:  rdata = remain[7:0];
            RA_CNT_HI:  rdata = 8'(remain[CNT_W-1:8]);
            RA_CTRL:    rdata = {4'h0, ctrl};
            RA_STAT:    rdata = {6'h00, short_en, done};
            RA_IRQEN:   rdata = {7'h00, irq_en};
            default:    rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/dar_seq.sv
module dar_seq
    import dar_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tok_in,
    input  logic                 host_ack,
    input  logic                 abort,
    input  ctrl_t                ctrl,
    input  logic [ADDR_W-1:0]    base,
    input  logic [CNT_W-1:0]     remain,
    output logic                 ram_rd,
    output logic [ADDR_W-1:0]    ram_addr,
    output logic                 tx_valid,
    output logic                 tx_last,
    output logic                 pkt_start,
    output logic [LEN_W-1:0]     pkt_len,
    output logic                 nak,
    output logic                 adv,
    output logic [LEN_W-1:0]     adv_len
);

    seq_state_e        state;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  idx;
    logic [LEN_W-1:0]  mps;
    rsp_t              rsp;

    assign mps = mps_bytes(ctrl.mps_sel);

    // Decide how an IN token would be answered from the current state.
    always_comb begin
        rsp.kind = RSP_NONE;
        rsp.len  = (remain < CNT_W'(mps)) ? remain[LEN_W-1:0] : mps;
        if (tok_in && ctrl.arm) begin
            if (ctrl.hold_off || remain == '0) rsp.kind = RSP_NAK;
            else                               rsp.kind = RSP_DATA;
        end
    end

    assign ram_rd   = (state == SQ_SEND);
    assign ram_addr = base + ADDR_W'(idx);
    assign adv      = (state == SQ_WAIT) && host_ack && !abort;
    assign adv_len  = len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            len_q     <= '0;
            idx       <= '0;
            pkt_start <= 1'b0;
            pkt_len   <= '0;
            nak       <= 1'b0;
            tx_valid  <= 1'b0;
            tx_last   <= 1'b0;
        end else begin
            pkt_start <= 1'b0;
            nak       <= 1'b0;
            tx_valid  <= ram_rd && !abort;
            tx_last   <= ram_rd && !abort && (idx == len_q - LEN_W'(1));
            if (abort) begin
                state <= SQ_IDLE;
                idx   <= '0;
            end else begin
                case (state)
                    SQ_SEND: begin
                        idx <= idx + LEN_W'(1);
                        if (idx == len_q - LEN_W'(1)) state <= SQ_WAIT;
                    end
                    SQ_IDLE, SQ_WAIT: begin
                        if (state == SQ_WAIT && host_ack) begin
                            state <= SQ_IDLE;
                        end else if (rsp.kind == RSP_NAK) begin
                            nak <= 1'b1;
                        end else if (rsp.kind == RSP_DATA) begin
                            state     <= SQ_SEND;
                            len_q     <= rsp.len;
                            idx       <= '0;
                            pkt_start <= 1'b1;
                            pkt_len   <= rsp.len;
                        end
                    end
                    default: state <= SQ_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/desc_auto_responder.sv
module desc_auto_responder
    import dar_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [2:0]          reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic                tok_in,
    input  logic                tok_out,
    input  logic                host_ack,
    output logic                ram_rd,
    output logic [ADDR_W-1:0]   ram_addr,
    input  logic [7:0]          ram_rdata,
    output logic                pkt_start,
    output logic [6:0]          pkt_len,
    output logic                tx_valid,
    output logic [7:0]          tx_data,
    output logic                tx_last,
    output logic                nak,
    output logic                short_en,
    output logic                irq
);

    ctrl_t              ctrl;
    logic [ADDR_W-1:0]  base;
    logic [CNT_W-1:0]   remain;
    logic               done;
    logic               irq_en;
    logic               adv;
    logic [LEN_W-1:0]   adv_len;
    logic               out_hit;

    assign out_hit = tok_out && ctrl.arm;

    dar_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .adv(adv), .adv_len(adv_len), .out_hit(out_hit),
        .base(base), .remain(remain), .ctrl(ctrl),
        .done(done), .irq_en(irq_en), .short_en(short_en)
    );

    dar_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst),
        .tok_in(tok_in), .host_ack(host_ack), .abort(out_hit),
        .ctrl(ctrl), .base(base), .remain(remain),
        .ram_rd(ram_rd), .ram_addr(ram_addr),
        .tx_valid(tx_valid), .tx_last(tx_last),
        .pkt_start(pkt_start), .pkt_len(pkt_len), .nak(nak),
        .adv(adv), .adv_len(adv_len)
    );

    assign tx_data = ram_rdata;
    assign irq     = done && irq_en;

endmodule

// File: rtl/dar_chk.sv
module dar_chk
    import dar_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        reg_we,
    input logic [2:0]  reg_addr,
    input logic [7:0]  reg_wdata,
    input logic        tok_out,
    input logic        pkt_start,
    input logic [6:0]  pkt_len,
    input logic        nak,
    input logic        tx_valid,
    input logic        tx_last,
    input ctrl_t       ctrl,
    input logic        done
);

    logic [6:0] mps_now;
    assign mps_now = mps_bytes(ctrl.mps_sel);

    // R2 / R5: a NAK and a packet start never answer the same token
    a_r2_nak_excl: assert property (@(posedge clk) disable iff (rst)
        nak |-> !pkt_start);

    // R3: announced length is nonzero and bounded by the max packet size
    a_r3_len_bound: assert property (@(posedge clk) disable iff (rst)
        pkt_start |-> (pkt_len != 7'd0) && (pkt_len <= mps_now));

    // R3: the last-byte marker only comes with a valid byte
    a_r3_last_valid: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid);

    // R7: status-stage OUT while armed disarms and sets done
    a_r7_out_done: assert property (@(posedge clk) disable iff (rst)
        (tok_out && ctrl.arm) |=> (!ctrl.arm && done));

    // R8: done stays set unless firmware writes 1 to it
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (done && !(reg_we && reg_addr == 3'd5 && reg_wdata[0])) |=> done);

    // R9: while disarmed no token is answered
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !ctrl.arm |=> (!pkt_start && !nak));

endmodule

bind desc_auto_responder dar_chk u_chk (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .tok_out(tok_out), .pkt_start(pkt_start), .pkt_len(pkt_len),
    .nak(nak), .tx_valid(tx_valid), .tx_last(tx_last),
    .ctrl(ctrl), .done(done)
);

// File: tb/desc_auto_responder_test.sv
module desc_auto_responder_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        tok_in = 1'b0;
    logic        tok_out = 1'b0;
    logic        host_ack = 1'b0;
    logic        ram_rd;
    logic [15:0] ram_addr;
    logic [7:0]  ram_rdata = 8'd0;
    logic        pkt_start;
    logic [6:0]  pkt_len;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic        nak;
    logic        short_en;
    logic        irq;

    int n_checks = 0;
    int n_errs   = 0;

    // vector: {start address, byte count, max-packet code}
    localparam logic [33:0] VEC [NVEC] = '{
        {16'h0100, 16'd18, 2'd0},
        {16'h1FF0, 16'd64, 2'd1},
        {16'h0040, 16'd5,  2'd3},
        {16'hFFFC, 16'd40, 2'd2}
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    always @(posedge clk) if (ram_rd) ram_rdata <= pat(ram_addr);

    desc_auto_responder uut (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tok_in(tok_in), .tok_out(tok_out), .host_ack(host_ack),
        .ram_rd(ram_rd), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
        .pkt_start(pkt_start), .pkt_len(pkt_len),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .nak(nak), .short_en(short_en), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse_ack();
        @(negedge clk); host_ack = 1'b1;
        @(negedge clk); host_ack = 1'b0;
    endtask

    task automatic pulse_out();
        @(negedge clk); tok_out = 1'b1;
        @(negedge clk); tok_out = 1'b0;
    endtask

    // Issue one IN token and collect what the block answers.
    task automatic do_in(input logic [15:0] exp_addr, output int nbytes,
                         output int naks, output int starts, output int bad,
                         output int lastpos, output int plen);
        nbytes = 0; naks = 0; starts = 0; bad = 0; lastpos = -1; plen = 0;
        @(negedge clk); tok_in = 1'b1;
        for (int i = 0; i < 72; i++) begin
            @(negedge clk); tok_in = 1'b0;
            if (nak) naks++;
            if (pkt_start) begin starts++; plen = pkt_len; end
            if (tx_valid) begin
                if (tx_data != pat(exp_addr + 16'(nbytes))) bad++;
                if (tx_last) lastpos = nbytes;
                nbytes++;
            end
        end
    endtask

    task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
        logic [7:0] l, h;
        rd(lo, l); rd(lo + 3'd1, h);
        v = {h, l};
    endtask

    task automatic load(input logic [15:0] a, input logic [15:0] c);
        wr(3'd0, a[7:0]); wr(3'd1, a[15:8]);
        wr(3'd2, c[7:0]); wr(3'd3, c[15:8]);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_errs++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        logic [7:0]  r;
        logic [15:0] v;
        int nb, nk, st, bd, lp, pl;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 / R10: reset values
        rd16(3'd0, v); check(v == 16'd0, "R1 addr", v, 0);
        rd16(3'd2, v); check(v == 16'd0, "R1 count", v, 0);
        rd(3'd4, r);   check(r == 8'h02, "R1 ctrl", r, 2);
        rd(3'd5, r);   check(r == 8'h00, "R1 stat", r, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);

        // R10: register placement readback
        load(16'hBEEF, 16'h1234);
        rd16(3'd0, v); check(v == 16'hBEEF, "R10 addr readback", v, 16'hBEEF);
        rd16(3'd2, v); check(v == 16'h1234, "R10 count readback", v, 16'h1234);
        wr(3'd6, 8'h01); rd(3'd6, r); check(r == 8'h01, "R10 irqen readback", r, 1);

        // R9: disarmed tokens are ignored
        do_in(16'hBEEF, nb, nk, st, bd, lp, pl);
        check(nk == 0 && st == 0 && nb == 0, "R9 IN while disarmed", nk + st + nb, 0);
        pulse_out();
        rd(3'd5, r); check(r[0] == 1'b0, "R9 OUT while disarmed", r[0], 0);

        // Table-driven full transfers: R2 R3 R4 R5 R6 R7 R8
        for (int k = 0; k < NVEC; k++) begin
            logic [15:0] a, c, rem;
            logic [1:0]  sel;
            int mps, ex;
            a = VEC[k][33:18]; c = VEC[k][17:2]; sel = VEC[k][1:0];
            mps = 8 << sel;
            load(a, c);
            wr(3'd4, {4'h0, sel, 2'b11});
            do_in(a, nb, nk, st, bd, lp, pl);
            check(nk == 1 && st == 0 && nb == 0, "R2 hold-off gives NAK", nk, 1);
            wr(3'd4, {4'h0, sel, 2'b01});
            rem = c;
            while (rem != 0) begin
                ex = (int'(rem) < mps) ? int'(rem) : mps;
                rd(3'd5, r);
                check(r[1] == (int'(rem) < mps) && short_en == r[1], "R6 short enable", r[1], int'(rem) < mps);
                do_in(a, nb, nk, st, bd, lp, pl);
                check(nb == ex && st == 1 && pl == ex && nk == 0, "R3 packet length", nb, ex);
                check(bd == 0 && lp == ex - 1, "R3 packet bytes", bd, 0);
                pulse_ack();
                a = a + 16'(ex); rem = rem - 16'(ex);
                rd16(3'd0, v); check(v == a, "R4 address advance", v, a);
            end
            rd16(3'd2, v); check(v == 16'd0, "R4 count drained", v, 0);
            rd(3'd5, r); check(r[1] == 1'b0, "R6 short off when empty", r[1], 0);
            do_in(a, nb, nk, st, bd, lp, pl);
            check(nk == 1 && st == 0 && nb == 0, "R5 NAK after last packet", nb + st, 0);
            pulse_out();
            rd(3'd5, r); check(r[0] == 1'b1, "R7 done set", r[0], 1);
            rd(3'd4, r); check(r[0] == 1'b0, "R7 disarmed", r[0], 0);
            check(irq == 1'b1, "R7 irq raised", irq, 1);
            wr(3'd5, 8'h00);
            rd(3'd5, r); check(r[0] == 1'b1, "R8 write 0 keeps done", r[0], 1);
            wr(3'd5, 8'h01);
            rd(3'd5, r); check(r[0] == 1'b0, "R8 W1C clears", r[0], 0);
        end

        // R4: no ack resends the same packet
        load(16'h0200, 16'd20);
        wr(3'd4, 8'h05);
        do_in(16'h0200, nb, nk, st, bd, lp, pl);
        check(nb == 16 && bd == 0, "R4 first send", nb, 16);
        do_in(16'h0200, nb, nk, st, bd, lp, pl);
        check(nb == 16 && bd == 0 && st == 1, "R4 resend without ack", nb, 16);
        rd16(3'd0, v); check(v == 16'h0200, "R4 address held", v, 16'h0200);
        rd16(3'd2, v); check(v == 16'd20, "R4 count held", v, 20);
        // hold-off raised while a packet awaits ack: IN is refused
        wr(3'd4, 8'h07);
        do_in(16'h0200, nb, nk, st, bd, lp, pl);
        check(nk == 1 && nb == 0, "R2 hold-off while pending", nb, 0);
        wr(3'd4, 8'h05);
        pulse_ack();
        rd16(3'd2, v); check(v == 16'd4, "R4 count after ack", v, 4);

        // R8: OUT and W1C in the same cycle, set wins
        @(negedge clk);
        tok_out = 1'b1; reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 8'h01;
        @(negedge clk);
        tok_out = 1'b0; reg_we = 1'b0;
        rd(3'd5, r); check(r[0] == 1'b1, "R8 set beats clear", r[0], 1);
        check(irq == 1'b1, "R7 irq after collision", irq, 1);
        wr(3'd6, 8'h00);
        check(irq == 1'b0, "R7 irq masked", irq, 0);
        wr(3'd5, 8'h01);

        // R5: armed with a zero count
        load(16'h0300, 16'd0);
        wr(3'd4, 8'h01);
        do_in(16'h0300, nb, nk, st, bd, lp, pl);
        check(nk == 1 && st == 0 && nb == 0, "R5 zero count NAK", nb + st, 0);
        pulse_out();
        rd(3'd5, r); check(r[0] == 1'b1, "R7 zero count completes", r[0], 1);

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule